// File: doc/BRIEF.md
# Fixed-Slot Time-Division Line Multiplexer

This block places a set of byte-wide sub-channels onto a single serial line using fixed time-division. Every frame opens with one marker bit, then gives each sub-channel one byte-long slot in ascending channel order. Each sub-channel owns a fixed share of the line. A silent sub-channel still uses its slot, and no other channel ever borrows that slot. With the defaults of 24 channels and 8-bit slots, one frame is 193 bits.

A matching receiver in the same top takes a serial line and an alignment flag that marks the marker bit. It returns each byte together with its slot number, and that slot number is the sub-channel address. The receiver also checks that the marker bit alternates from frame to frame. Both directions move forward only on a shared bit enable, so the line rate can be any fraction of the clock.

Top module: `tdm_frame_mux`

## Requirements
- R1: After reset, `line_out` carries a marker bit of value 0, `tx_mark` is 1, and `rx_valid` and `rx_err` are 0.
- R2: A frame is 1 + CHANNELS*SLOT_W enabled bits long (193 by default). `tx_mark` is 1 for exactly the first bit of each frame and 0 for all other bits.
- R3: The marker bit is 0 in the first frame after reset and inverts in every later frame.
- R4: After the marker, slot k (k = 1..CHANNELS) carries `tx_bytes[k*SLOT_W-1 -: SLOT_W]`, sent most significant bit first.
- R5: `tx_bytes` is captured on the enabled clock that sends the last payload bit of a frame, and the next frame sends those captured values. A change to `tx_bytes` at any other time has no effect on the current frame. The first frame after reset has an all-zero payload.
- R6: Transmitter and receiver state change only on clock edges where `bit_en` is 1. On other edges `line_out` holds and `rx_valid` stays 0.
- R7: On the enabled edge that receives the last bit of slot k, the receiver raises `rx_valid` for exactly one clock, with `rx_addr` = k and `rx_byte` equal to the slot contents (first received bit as the MSB). This holds for every slot, including slots whose byte is all zeros.
- R8: When the bit received with `rx_mark` = 1 differs from the expected marker value, `rx_err` pulses for one clock. The expected value starts at 0 and inverts at every marker, whatever value arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One line bit per clock where this is high |
| tx_bytes | input | CHANNELS*SLOT_W | Sub-channel bytes; channel k occupies bits [k*SLOT_W-1 -: SLOT_W] |
| line_out | output | 1 | Serial transmit line |
| tx_mark | output | 1 | High while `line_out` carries the marker bit |
| line_in | input | 1 | Serial receive line |
| rx_mark | input | 1 | Alignment: high while `line_in` carries the marker bit |
| rx_valid | output | 1 | One-clock strobe when a slot byte is complete |
| rx_addr | output | $clog2(CHANNELS+1) | Slot number (1..CHANNELS) of the completed byte |
| rx_byte | output | SLOT_W | Received slot contents |
| rx_err | output | 1 | One-clock marker mismatch flag |

## Verification
Two events can fall on the same enabled edge at the frame wrap. The transmitter loads the holding registers for the next frame, and the receiver delivers the last slot of the frame that is ending. The bench provokes this collision by changing `tx_bytes` in the middle of a frame and again just before the wrap. It then checks that the slot delivered on the wrap edge still carries the old frame's byte, and that the following frame carries the new bytes. A second collision occurs when a flipped marker arrives while the expected-marker toggle happens. This is judged by an error pulse in that frame only, with the frame after it clean.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   function automatic int frame_bits(input int channels, input int slot_w);
      return 1 + channels * slot_w;
   endfunction

   function automatic int idx_w(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction
endpackage

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx #(
   parameter int CHANNELS = 24,
   parameter int SLOT_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_en,
   input  logic [CHANNELS*SLOT_W-1:0] in_bytes,
   output logic                       line_out,
   output logic                       mark_out
);
   localparam int CW = tdm_pkg::idx_w(CHANNELS);
   localparam int BW = tdm_pkg::idx_w(SLOT_W);
   localparam logic [CW-1:0] CH_LAST  = CW'(CHANNELS - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_W - 1);

   logic              in_mark;
   logic              par;
   logic [CW-1:0]     ch;
   logic [BW-1:0]     bitp;
   logic [SLOT_W-1:0] hold [CHANNELS];
   logic              last_payload;

   assign last_payload = !in_mark && (ch == CH_LAST) && (bitp == BIT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_mark <= 1'b1;
         par     <= 1'b0;
         ch      <= '0;
         bitp    <= '0;
      end else if (bit_en) begin
         if (in_mark) begin
            in_mark <= 1'b0;
            ch      <= '0;
            bitp    <= '0;
         end else if (bitp == BIT_LAST) begin
            bitp <= '0;
            if (ch == CH_LAST) begin
               in_mark <= 1'b1;
               par     <= ~par;
               ch      <= '0;
            end else begin
               ch <= ch + 1'b1;
            end
         end else begin
            bitp <= bitp + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < CHANNELS; g++) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold[g] <= '0;
         else if (bit_en && last_payload)
            hold[g] <= in_bytes[g*SLOT_W +: SLOT_W];
      end
   end

   assign line_out = in_mark ? par : hold[ch][BIT_LAST - bitp];
   assign mark_out = in_mark;

   // R3: marker value changes every time a new frame begins
   a_r3_marker_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_mark) |-> (par != $past(par)));

   // R2: marker lasts one enabled bit only
   a_r2_marker_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (in_mark && bit_en) |=> !in_mark);

   // R6: no state movement without enable
   a_r6_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(ch) && $stable(bitp) && $stable(in_mark)));
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
   parameter int CHANNELS = 24,
   parameter int SLOT_W   = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bit_en,
   input  logic                                line_in,
   input  logic                                mark_in,
   output logic                                valid,
   output logic [$clog2(CHANNELS+1)-1:0]       addr,
   output logic [SLOT_W-1:0]                   data,
   output logic                                err
);
   localparam int CW  = tdm_pkg::idx_w(CHANNELS);
   localparam int BW  = tdm_pkg::idx_w(SLOT_W);
   localparam int AW  = $clog2(CHANNELS+1);
   localparam int SRW = SLOT_W - 1;
   localparam logic [CW-1:0] CH_LAST  = CW'(CHANNELS - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(SLOT_W - 1);

   logic           armed;
   logic           exp_par;
   logic [CW-1:0]  ch;
   logic [BW-1:0]  bitp;
   logic [SRW-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         exp_par <= 1'b0;
         ch      <= '0;
         bitp    <= '0;
         sr      <= '0;
         valid   <= 1'b0;
         err     <= 1'b0;
         addr    <= '0;
         data    <= '0;
      end else begin
         valid <= 1'b0;
         err   <= 1'b0;
         if (bit_en) begin
            if (mark_in) begin
               err     <= (line_in != exp_par);
               exp_par <= ~exp_par;
               armed   <= 1'b1;
               ch      <= '0;
               bitp    <= '0;
            end else if (armed) begin
               sr <= SRW'({sr, line_in});
               if (bitp == BIT_LAST) begin
                  valid <= 1'b1;
                  data  <= {sr, line_in};
                  addr  <= AW'(ch) + AW'(1);
                  bitp  <= '0;
                  if (ch == CH_LAST) armed <= 1'b0;
                  else               ch    <= ch + 1'b1;
               end else begin
                  bitp <= bitp + 1'b1;
               end
            end
         end
      end
   end

   // R7: strobe is a single clock wide
   a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R7: address stays within the slot numbering
   a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (addr >= AW'(1) && addr <= AW'(CHANNELS)));

   // R8: an error only follows an enabled marker bit
   a_r8_err_after_marker: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(mark_in && bit_en));

   // R6: no delivery without enable on the previous edge
   a_r6_valid_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(bit_en));
endmodule

// File: rtl/tdm_frame_mux.sv
module tdm_frame_mux #(
   parameter int CHANNELS = 24,
   parameter int SLOT_W   = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bit_en,
   input  logic [CHANNELS*SLOT_W-1:0]    tx_bytes,
   output logic                          line_out,
   output logic                          tx_mark,
   input  logic                          line_in,
   input  logic                          rx_mark,
   output logic                          rx_valid,
   output logic [$clog2(CHANNELS+1)-1:0] rx_addr,
   output logic [SLOT_W-1:0]             rx_byte,
   output logic                          rx_err
);
   localparam int FRAME = tdm_pkg::frame_bits(CHANNELS, SLOT_W);

   if (CHANNELS < 2) begin : g_bad_ch
      $error("tdm_frame_mux: CHANNELS must be at least 2");
   end
   if (SLOT_W < 2) begin : g_bad_w
      $error("tdm_frame_mux: SLOT_W must be at least 2");
   end
   if (FRAME < 5) begin : g_bad_frame
      $error("tdm_frame_mux: frame too short");
   end

   tdm_frame_tx #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .in_bytes (tx_bytes),
      .line_out (line_out),
      .mark_out (tx_mark)
   );

   tdm_frame_rx #(.CHANNELS(CHANNELS), .SLOT_W(SLOT_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .line_in (line_in),
      .mark_in (rx_mark),
      .valid   (rx_valid),
      .addr    (rx_addr),
      .data    (rx_byte),
      .err     (rx_err)
   );
endmodule

// File: tb/tdm_frame_mux_tb.sv
module tdm_frame_mux_tb_top;
   localparam int NCH = 24;
   localparam int W   = 8;
   localparam int FB  = 1 + NCH * W;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bit_en = 1'b0;
   logic [NCH*W-1:0] tx_bytes;
   logic           line_out, tx_mark, line_in, rx_valid, rx_err;
   logic [4:0]     rx_addr;
   logic [W-1:0]   rx_byte;
   logic           inj = 1'b0;

   logic [W-1:0] cur_in [NCH];
   logic [W-1:0] pay [2][NCH];
   int  n = 0;
   logic last_en = 1'b0;
   logic inj_last = 1'b0;
   bit  mon_on = 1'b0;
   int  checks = 0;
   int  errors = 0;
   int  valid_seen = 0;
   int  err_seen = 0;

   always #10 clk = ~clk;

   always_comb
      for (int k = 0; k < NCH; k++) tx_bytes[k*W +: W] = cur_in[k];

   assign line_in = line_out ^ inj;

   tdm_frame_mux #(.CHANNELS(NCH), .SLOT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bytes(tx_bytes),
      .line_out(line_out), .tx_mark(tx_mark), .line_in(line_in),
      .rx_mark(tx_mark), .rx_valid(rx_valid), .rx_addr(rx_addr),
      .rx_byte(rx_byte), .rx_err(rx_err));

   // bench-side frame position model
   always @(posedge clk) begin
      if (!rst_n) begin
         n <= 0;
         last_en <= 1'b0;
         inj_last <= 1'b0;
         for (int k = 0; k < NCH; k++) begin
            pay[0][k] <= '0;
            pay[1][k] <= '0;
         end
      end else begin
         last_en  <= bit_en;
         inj_last <= bit_en && inj;
         if (bit_en) begin
            n <= n + 1;
            if (n % FB == FB - 1)
               for (int k = 0; k < NCH; k++) pay[((n + 1) / FB) % 2][k] <= cur_in[k];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // per-cycle monitor, samples at the falling edge
   always @(negedge clk) begin
      if (mon_on) begin
         int pos, f, p, ch, b;
         logic exp_line;
         pos = n % FB;
         f   = n / FB;
         if (pos == 0) exp_line = logic'(f % 2);
         else begin
            ch = (pos - 1) / W;
            b  = (pos - 1) % W;
            exp_line = pay[f % 2][ch][W-1-b];
         end
         if (pos == 0) chk(line_out == exp_line, "R3 marker value", int'(line_out), int'(exp_line));
         else          chk(line_out == exp_line, "R4/R5 payload bit", int'(line_out), int'(exp_line));
         chk(tx_mark == (pos == 0), "R2 marker position", int'(tx_mark), int'(pos == 0));
         if (last_en && n >= 1 && ((n - 1) % FB) != 0 && (((n - 1) % FB) % W) == 0) begin
            p = (n - 1) % FB;
            valid_seen++;
            chk(rx_valid == 1'b1, "R7 valid strobe", int'(rx_valid), 1);
            chk(rx_addr == 5'(p / W), "R7 slot address", int'(rx_addr), p / W);
            chk(rx_byte == pay[((n - 1) / FB) % 2][p / W - 1], "R7 slot byte",
                int'(rx_byte), int'(pay[((n - 1) / FB) % 2][p / W - 1]));
         end else begin
            chk(rx_valid == 1'b0, "R6/R7 no strobe", int'(rx_valid), 0);
         end
         chk(rx_err == inj_last, "R8 marker check", int'(rx_err), int'(inj_last));
         if (rx_err) err_seen++;
      end
   end

   task automatic set_inputs(input int pattern);
      for (int k = 0; k < NCH; k++)
         case (pattern)
            0: cur_in[k] = W'(k + 1);
            1: cur_in[k] = (k % 2 == 0) ? 8'hA5 : 8'h5A;
            2: cur_in[k] = (k == 7) ? 8'h81 : 8'h00;
            default: cur_in[k] = W'(8'hF0 ^ (k * 13));
         endcase
   endtask

   task automatic run_cycles(input int cnt, input int gap_mode);
      for (int i = 0; i < cnt; i++) begin
         @(negedge clk);
         #1;
         bit_en = (gap_mode == 0) ? 1'b1 : ((i % 3) != 0);
      end
   endtask

   task automatic t_reset();
      set_inputs(0);
      rst_n = 1'b0;
      bit_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk(line_out == 1'b0, "R1 reset marker value", int'(line_out), 0);
      chk(tx_mark == 1'b1, "R1 reset marker flag", int'(tx_mark), 1);
      chk(rx_valid == 1'b0, "R1 reset valid", int'(rx_valid), 0);
      chk(rx_err == 1'b0, "R1 reset err", int'(rx_err), 0);
      mon_on = 1'b1;
   endtask

   task automatic t_stream();
      int v0;
      v0 = valid_seen;
      // frame 0 carries zeros, inputs change mid-frame (R5)
      run_cycles(FB / 2, 0);
      set_inputs(1);
      run_cycles(FB - FB / 2 - 3, 0);
      set_inputs(2);                 // just before the wrap: captured
      run_cycles(FB + 60, 0);
      set_inputs(3);                 // mid-frame: must not show until next frame
      run_cycles(2 * FB, 0);
      chk(valid_seen - v0 >= 3 * NCH, "R7 every slot delivered", valid_seen - v0, 3 * NCH);
   endtask

   task automatic t_gaps();
      set_inputs(0);
      run_cycles(3 * FB, 1);          // bit_en low one cycle in three (R6)
      @(negedge clk); #1; bit_en = 1'b1;
   endtask

   task automatic t_marker_err();
      int e0;
      e0 = err_seen;
      while (n % FB != 0) begin @(negedge clk); #1; end
      inj = 1'b1;                    // flip the marker bit on the line (R8)
      @(negedge clk); #1;
      inj = 1'b0;
      run_cycles(FB + 5, 0);
      chk(err_seen - e0 == 1, "R8 single error pulse", err_seen - e0, 1);
   endtask

   initial begin
      for (int k = 0; k < NCH; k++) cur_in[k] = '0;
      t_reset();
      t_stream();
      t_gaps();
      t_marker_err();
      mon_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule